// File: doc/BRIEF.md
# SDRAM Command Decoder with Mode Register

This block sits on the device side of a synchronous DRAM interface. On every rising clock edge it samples chip select, the three command strobes (row strobe, column strobe, write enable), the address bus and the bank-select bits. It turns each sample into one decoded operation: mode programming, row open, read, write, bank close, or burst stop. It holds the programmed burst length, burst ordering and read latency. It also keeps a record of which banks have an open row and how long ago each row was opened.

Any command that breaks an ordering or state rule is dropped, and a one-cycle error pulse is raised in its place. When a read or write is accepted, the block walks the column addresses of the burst one per cycle, in sequential or interleaved order and inside the burst-length-aligned window. In full-page mode the walk does not stop on its own. The decoded operation, the mode fields, the open-bank vector and the burst column are all outputs, so the memory array and the data path can be driven from them.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: When `cs_n` is high the sample is ignored: `op_kind` reads 0 (no operation), no error is raised and no state changes. The same applies when chip select is low with all three strobes high, and when it is low with `ras_n`/`cas_n` low and `we_n` high (a refresh, which is outside this block).
- R2: Pin decode, with 0 meaning low: `ras_n`/`cas_n`/`we_n` = 000 is mode set (op 1), 011 is row open (op 2), 101 is read (op 3), 100 is write (op 4), 010 is bank close (op 5), 110 is burst stop (op 6). An accepted mode set loads `addr[2:0]` into `mr_bl`, `addr[3]` into `mr_bt` and `addr[6:4]` into `mr_cl`. These values appear on the cycle after the edge. The mode can be reprogrammed any number of times.
- R3: A mode set is dropped with an error, and the mode fields are left unchanged, unless all three of these hold: no bank is open, `ba` is 0, and `cke` was high on that edge and on the edge before it.
- R4: A mode set is also dropped with an error when it asks for an unsupported mode. The supported burst-length codes are 000=1, 001=2, 010=4, 011=8 and 111=full page. The supported latency codes are 2 and 3. Full page combined with interleaved ordering (`addr[3]`=1) is not supported.
- R5: A row open is accepted only if a mode set has been accepted since reset and the addressed bank is idle. On acceptance, bit `ba` of `bank_open` goes high.
- R6: A read or write is accepted only if the addressed bank is open and at least TRCD clock edges have passed since the edge that opened it. For example, a row opened at edge k makes a read legal from edge k+TRCD onward.
- R7: A bank close is always accepted. With `addr[10]` high it closes every bank; otherwise it closes bank `ba`. Any accepted bank close or burst stop ends a running burst.
- R8: With sequential ordering (`mr_bt`=0) and burst length BL, beat i of a burst that starts at column c is placed on `bst_col` i cycles after the edge of the command. Its value is the upper bits of c with the low log2(BL) bits set to (c mod BL + i) mod BL. `bst_act` is high for exactly BL cycles.
- R9: With interleaved ordering (`mr_bt`=1), the low log2(BL) bits of beat i are (c mod BL) XOR i.
- R10: In full-page mode the burst counts sequentially through the whole column field, wrapping at the top. It continues until a burst stop, a bank close, or a new accepted read or write, which restarts the burst.
- R11: Each dropped command produces `cmd_err` high for exactly the one cycle after its edge, with `op_kind` 0 in that cycle. Back-to-back illegal commands give back-to-back pulses.
- R12: After reset: `op_kind` is 0, `cmd_err` is 0, no bank is open, the mode fields are 0, no burst is running, and no mode is considered programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples the command |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin, gates mode programming |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Row, column or mode word |
| ba | input | BA_W | Bank select |
| op_kind | output | 3 | Decoded operation of the last edge (0 none) |
| op_bank | output | BA_W | Bank of the decoded operation |
| op_addr | output | ADDR_W | Address of the decoded operation |
| cmd_err | output | 1 | One-cycle pulse for a dropped command |
| bank_open | output | 2**BA_W | One bit per bank, high while a row is open |
| mr_bl | output | 3 | Programmed burst-length code |
| mr_bt | output | 1 | Programmed burst ordering, 1 interleaved |
| mr_cl | output | 3 | Programmed read-latency code |
| bst_act | output | 1 | High while a burst beat is presented |
| bst_col | output | COL_W | Column address of the current beat |

## Verification
The bench aims at the mode-set gate from every side. It issues a mode set with a nonzero bank, one with `cke` high only on that edge, one with a bank left open, and the three unsupported codes. A gate that checks too little would change `mr_*` on one of these and fail to raise the error. It opens a bank and then reads it one edge too early and then exactly at the edge where the row-to-column delay is met, so an off-by-one in the delay count shows up as a missing or spurious error. Burst walks start at columns that are not aligned, so the wrap inside the window and the XOR order are both exposed. A full-page write runs across the top of the column field and is then cut off by a stop, a restart and a bank close. A design that lets the burst end on its own, or ignores the cut-off, shows a wrong `bst_act` or `bst_col`.

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder #(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int COL_W  = 8,
  parameter int TRCD   = 3,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BA_W-1:0]   ba,
  output logic [2:0]        op_kind,
  output logic [BA_W-1:0]   op_bank,
  output logic [ADDR_W-1:0] op_addr,
  output logic              cmd_err,
  output logic [(1<<BA_W)-1:0] bank_open,
  output logic [2:0]        mr_bl,
  output logic              mr_bt,
  output logic [2:0]        mr_cl,
  output logic              bst_act,
  output logic [COL_W-1:0]  bst_col
);
  localparam int NB    = 1 << BA_W;
  localparam int CNT_W = (TRCD < 2) ? 1 : $clog2(TRCD + 1);
  localparam logic [CNT_W-1:0] RCD_INIT = CNT_W'(TRCD - 1);

  localparam logic [2:0] OP_NONE = 3'd0, OP_MODE = 3'd1, OP_ACT = 3'd2,
                         OP_RD = 3'd3, OP_WR = 3'd4, OP_PRE = 3'd5, OP_STOP = 3'd6;

  function automatic logic [COL_W-1:0] win_mask(input logic [2:0] code);
    case (code)
      3'd0:    win_mask = '0;
      3'd1:    win_mask = COL_W'(1);
      3'd2:    win_mask = COL_W'(3);
      3'd3:    win_mask = COL_W'(7);
      default: win_mask = '1;
    endcase
  endfunction

  wire sel     = !cs_n;
  wire is_mode = sel && !ras_n && !cas_n && !we_n;
  wire is_act  = sel && !ras_n &&  cas_n &&  we_n;
  wire is_pre  = sel && !ras_n &&  cas_n && !we_n;
  wire is_rd   = sel &&  ras_n && !cas_n &&  we_n;
  wire is_wr   = sel &&  ras_n && !cas_n && !we_n;
  wire is_stop = sel &&  ras_n &&  cas_n && !we_n;

  logic                 cke_q, mode_ok_q;
  logic [NB-1:0]        open_q;
  logic [CNT_W-1:0]     rcd_q [NB];
  logic [2:0]           op_q;
  logic                 err_q;

  wire bl_ok   = !addr[2] || (addr[2:0] == 3'b111);
  wire cl_ok   = (addr[6:4] == 3'd2) || (addr[6:4] == 3'd3);
  wire fp_ilv  = (addr[2:0] == 3'b111) && addr[3];
  wire mode_go = (open_q == '0) && (ba == '0) && cke && cke_q && bl_ok && cl_ok && !fp_ilv;
  wire act_go  = mode_ok_q && !open_q[ba];
  wire rw_go   = open_q[ba] && (rcd_q[ba] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b0;
      mode_ok_q <= 1'b0;
      open_q    <= '0;
      for (int b = 0; b < NB; b++) rcd_q[b] <= '0;
      op_q      <= OP_NONE;
      err_q     <= 1'b0;
      op_bank   <= '0;
      op_addr   <= '0;
      mr_bl     <= '0;
      mr_bt     <= 1'b0;
      mr_cl     <= '0;
    end else begin
      cke_q   <= cke;
      op_q    <= OP_NONE;
      err_q   <= 1'b0;
      op_bank <= ba;
      op_addr <= addr;
      for (int b = 0; b < NB; b++)
        if (rcd_q[b] != '0) rcd_q[b] <= rcd_q[b] - 1'b1;
      if (is_mode) begin
        if (mode_go) begin
          op_q      <= OP_MODE;
          mode_ok_q <= 1'b1;
          mr_bl     <= addr[2:0];
          mr_bt     <= addr[3];
          mr_cl     <= addr[6:4];
        end else err_q <= 1'b1;
      end else if (is_act) begin
        if (act_go) begin
          op_q       <= OP_ACT;
          open_q[ba] <= 1'b1;
          rcd_q[ba]  <= RCD_INIT;
        end else err_q <= 1'b1;
      end else if (is_rd || is_wr) begin
        if (rw_go) op_q <= is_rd ? OP_RD : OP_WR;
        else       err_q <= 1'b1;
      end else if (is_pre) begin
        op_q <= OP_PRE;
        if (addr[AP_BIT]) open_q <= '0;
        else              open_q[ba] <= 1'b0;
      end else if (is_stop) begin
        op_q <= OP_STOP;
      end
    end
  end

  logic [COL_W-1:0] b_base, b_idx, b_mask;
  logic             b_ilv, b_full;

  wire b_last  = !b_full && (b_idx == b_mask);
  wire b_start = (is_rd || is_wr) && rw_go;
  wire b_kill  = is_pre || is_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst_act <= 1'b0;
      b_base  <= '0;
      b_idx   <= '0;
      b_mask  <= '0;
      b_ilv   <= 1'b0;
      b_full  <= 1'b0;
    end else if (b_start) begin
      bst_act <= 1'b1;
      b_base  <= addr[COL_W-1:0];
      b_idx   <= '0;
      b_mask  <= win_mask(mr_bl);
      b_ilv   <= mr_bt;
      b_full  <= (mr_bl == 3'b111);
    end else if (b_kill) begin
      bst_act <= 1'b0;
    end else if (bst_act) begin
      if (b_last) bst_act <= 1'b0;
      else        b_idx   <= b_idx + 1'b1;
    end
  end

  wire [COL_W-1:0] b_low = b_ilv ? (b_base ^ b_idx) : (b_base + b_idx);

  assign bst_col   = (b_base & ~b_mask) | (b_low & b_mask);
  assign op_kind   = op_q;
  assign cmd_err   = err_q;
  assign bank_open = open_q;

endmodule

// File: rtl/sdram_cmd_decoder_chk.sv
module sdram_cmd_decoder_chk #(
  parameter int BA_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               ras_n,
  input logic               cas_n,
  input logic               we_n,
  input logic               pre_all,
  input logic [2:0]         op_kind,
  input logic [BA_W-1:0]    op_bank,
  input logic               cmd_err,
  input logic [(1<<BA_W)-1:0] bank_open,
  input logic [2:0]         mr_bl,
  input logic               mr_bt,
  input logic [2:0]         mr_cl
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  wire mode_pins = !cs_n && !ras_n && !cas_n && !we_n;
  wire pre_pins  = !cs_n && !ras_n &&  cas_n && !we_n;

  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (op_kind == 3'd0 && !cmd_err && $stable(bank_open)));

  // R11
  err_drops_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> op_kind == 3'd0);

  // R5
  act_marks_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == 3'd2) |-> bank_open[op_bank]);

  // R6
  rw_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == 3'd3 || op_kind == 3'd4) |-> bank_open[op_bank]);

  // R3
  mode_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pins && bank_open != '0) |=> (cmd_err && $stable({mr_bl, mr_bt, mr_cl})));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && op_kind != 3'd1) |-> $stable({mr_bl, mr_bt, mr_cl}));

  // R4
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == 3'd1) |-> ((mr_cl == 3'd2 || mr_cl == 3'd3) &&
                           (!mr_bl[2] || mr_bl == 3'd7) && !(mr_bl == 3'd7 && mr_bt)));

  // R7
  close_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_pins && pre_all) |=> (bank_open == '0 && op_kind == 3'd5));
endmodule

bind sdram_cmd_decoder sdram_cmd_decoder_chk #(.BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .pre_all(addr[AP_BIT]), .op_kind(op_kind), .op_bank(op_bank), .cmd_err(cmd_err),
  .bank_open(bank_open), .mr_bl(mr_bl), .mr_bt(mr_bt), .mr_cl(mr_cl)
);

// File: tb/sdram_cmd_decoder_tb.sv
`timescale 1ns/1ps
module sdram_cmd_decoder_tb;
  localparam int TRCD = 3;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [1:0]  ba = '0;
  logic [2:0]  op_kind, mr_bl, mr_cl;
  logic [1:0]  op_bank;
  logic [11:0] op_addr;
  logic        cmd_err, mr_bt, bst_act;
  logic [3:0]  bank_open;
  logic [7:0]  bst_col;

  always #2 clk = ~clk;

  sdram_cmd_decoder #(.ADDR_W(12), .BA_W(2), .COL_W(8), .TRCD(TRCD), .AP_BIT(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .op_kind(op_kind), .op_bank(op_bank),
    .op_addr(op_addr), .cmd_err(cmd_err), .bank_open(bank_open), .mr_bl(mr_bl),
    .mr_bt(mr_bt), .mr_cl(mr_cl), .bst_act(bst_act), .bst_col(bst_col));

  int vectors = 0, fails = 0;
  string tag = "R12";
  bit done = 0;

  int m_open [4];
  int m_age  [4];
  int m_mode, m_bl, m_bt, m_cl, m_op, m_err, m_bank, m_addr, m_cke_prev;
  int m_bact, m_base, m_i, m_len, m_ilv;

  task automatic m_reset();
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_age[b] = 0; end
    m_mode = 0; m_bl = 0; m_bt = 0; m_cl = 0; m_op = 0; m_err = 0;
    m_bank = 0; m_addr = 0; m_cke_prev = 0; m_bact = 0; m_base = 0; m_i = 0;
    m_len = 1; m_ilv = 0;
  endtask

  initial m_reset();

  function automatic int len_of(int code);
    case (code) 0: return 1; 1: return 2; 2: return 4; 3: return 8; default: return 0; endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      int r, c, w, b, a, any_open;
      bit valid;
      r = ras_n; c = cas_n; w = we_n; b = ba; a = addr;
      m_op = 0; m_err = 0; m_bank = b; m_addr = a;
      any_open = 0;
      for (int k = 0; k < 4; k++) begin
        if (m_age[k] < 1000) m_age[k]++;
        any_open += m_open[k];
      end
      if (m_bact) begin
        m_i++;
        if (m_len != 0 && m_i == m_len) m_bact = 0;
      end
      if (!cs_n) begin
        if (r == 0 && c == 0 && w == 0) begin
          valid = (a[2:0] inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd7}) && (a[6:4] inside {3'd2, 3'd3})
                  && !(a[2:0] == 7 && a[3] == 1);
          if (any_open == 0 && b == 0 && cke && m_cke_prev && valid) begin
            m_op = 1; m_mode = 1; m_bl = a[2:0]; m_bt = a[3]; m_cl = a[6:4];
          end else m_err = 1;
        end else if (r == 0 && c == 1 && w == 1) begin
          if (m_mode && !m_open[b]) begin m_op = 2; m_open[b] = 1; m_age[b] = 0; end
          else m_err = 1;
        end else if (r == 1 && c == 0) begin
          if (m_open[b] && m_age[b] >= TRCD) begin
            m_op = (w == 1) ? 3 : 4;
            m_bact = 1; m_base = a % 256; m_i = 0; m_len = len_of(m_bl); m_ilv = m_bt;
          end else m_err = 1;
        end else if (r == 0 && c == 1 && w == 0) begin
          m_op = 5; m_bact = 0;
          if (a[10]) for (int k = 0; k < 4; k++) m_open[k] = 0;
          else m_open[b] = 0;
        end else if (r == 1 && c == 1 && w == 0) begin
          m_op = 6; m_bact = 0;
        end
      end
      m_cke_prev = cke;
    end
  end

  task automatic chk(input int got, input int exp, input string what);
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    int blk, lo, off;
    vectors++;
    chk(op_kind, m_op, "op_kind");
    chk(cmd_err, m_err, "cmd_err");
    chk(bank_open, m_open[0] + 2*m_open[1] + 4*m_open[2] + 8*m_open[3], "bank_open");
    chk(mr_bl, m_bl, "mr_bl");
    chk(mr_bt, m_bt, "mr_bt");
    chk(mr_cl, m_cl, "mr_cl");
    chk(bst_act, m_bact, "bst_act");
    if (m_op != 0) begin
      chk(op_bank, m_bank, "op_bank");
      chk(op_addr, m_addr, "op_addr");
    end
    if (m_bact) begin
      blk = (m_len == 0) ? 256 : m_len;
      lo  = m_base % blk;
      off = m_ilv ? (lo ^ (m_i % blk)) : ((lo + m_i) % blk);
      chk(bst_col, (m_base - lo) + off, "bst_col");
    end
  end

  task automatic pins(input logic c, input logic r, input logic ca, input logic w,
                      input int b, input int a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = 2'(b); addr = 12'(a);
    @(negedge clk);
  endtask
  task automatic nop(input int n);
    for (int k = 0; k < n; k++) pins(0, 1, 1, 1, 0, 0);
  endtask
  task automatic mode(input int b, input int a); pins(0, 0, 0, 0, b, a); endtask
  task automatic act(input int b, input int row); pins(0, 0, 1, 1, b, row); endtask
  task automatic rd(input int b, input int col); pins(0, 1, 0, 1, b, col); endtask
  task automatic wr(input int b, input int col); pins(0, 1, 0, 0, b, col); endtask
  task automatic pre(input int b, input bit all); pins(0, 0, 1, 0, b, all ? 12'h400 : 0); endtask
  task automatic stp(); pins(0, 1, 1, 0, 0, 0); endtask

  initial begin
    #9 @(negedge clk);
    tag = "R12"; nop(1);
    rst_n = 1'b1; nop(3);

    tag = "R5";  act(0, 12'h055); nop(1);
    tag = "R1";  pins(1, 0, 0, 0, 0, 12'h022); pins(1, 0, 1, 1, 1, 0); pins(0, 0, 0, 1, 0, 0); nop(1);

    tag = "R3";  mode(1, 12'h022); nop(1);
    cke = 1'b0; nop(1); cke = 1'b1; mode(0, 12'h022); nop(1);
    tag = "R4";  mode(0, 12'h024); mode(0, 12'h012); mode(0, 12'h02F); nop(1);
    tag = "R2";  mode(0, 12'h022); nop(1);

    tag = "R5";  act(0, 12'h123); act(0, 12'h0AA);
    tag = "R6";  rd(0, 5); rd(0, 5);
    tag = "R8";  nop(4);
    tag = "R3";  mode(0, 12'h030); nop(1);
    tag = "R6";  rd(1, 3); wr(0, 6); nop(4);
    tag = "R11"; rd(2, 0); act(0, 0); nop(1);
    tag = "R7";  pre(0, 0); nop(1);

    tag = "R2";  mode(0, 12'h03B); act(2, 12'h777); nop(2);
    tag = "R9";  rd(2, 12'h012); nop(9); wr(2, 12'h0F5); nop(9);
    tag = "R7";  act(1, 12'h001); nop(1); pre(0, 1); nop(2);

    tag = "R2";  mode(0, 12'h027); act(3, 12'h0FF); nop(2);
    tag = "R10"; wr(3, 12'h0FE); nop(6); stp(); nop(2);
    rd(3, 12'h010); nop(3); rd(3, 12'h080); nop(300);
    tag = "R7";  pre(3, 0); nop(2);

    tag = "R8";  mode(0, 12'h030); act(1, 12'h002); nop(2); rd(1, 12'h0C7); nop(3);
    mode(0, 12'h021); pre(1, 0); mode(0, 12'h021); act(1, 0); nop(2); wr(1, 12'h003); nop(3);
    tag = "R1";  pins(0, 0, 0, 1, 0, 0); pins(1, 1, 0, 1, 1, 0); nop(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule